// File: doc/BRIEF.md
# Vector-Fetch Boot Interceptor

This block sits beside a 65C02-class CPU on a board that has no boot ROM. It watches the CPU's active-low vector-pull strobe and the three lowest address lines, and so catches the fetch of the reset vector without decoding the upper address bits. It can also catch the NMI vector. If that fetch comes while the external loader is still writing bootstrap code into RAM, the block pulls RDY low and holds the CPU in the fetch cycle. When the loader signals that it has finished, RDY is released. The block then returns a 16-bit entry address as the two vector bytes. It drives the data bus itself and inhibits the RAM outputs while it does so.

After both vector bytes have been supplied, the block disarms itself. Any vector fetch after that reads memory normally, until the next reset. All logic runs on one fast synchronous clock. The CPU's phase-2 clock is an input level that the block samples on that clock. RDY is changed only on samples taken while phase 2 is low.

Top module: `vec_boot_intercept`

## Requirements
- R1: While reset is applied and after reset is released, `rdy` is 1 and `data_oe` and `mem_inhibit` are 0.
- R2: A reset-vector low-byte fetch has `vp_n` = 0 and `addr_lo` = 3'b100. If that fetch occurs while armed and before a load-done has been seen, `rdy` goes to 0 on the first clock edge that samples `phi2` low.
- R3: `rdy` is updated only on clock edges that sample `phi2` = 0. On an edge that samples `phi2` = 1, `rdy` holds its value.
- R4: After `load_done` has been seen, a stalled fetch releases `rdy` to 1 on the next edge that samples `phi2` low.
- R5: A low-byte vector fetch that occurs while armed and after load-done makes the block drive `entry_addr[7:0]` on `data_o` with `data_oe` = 1. This takes effect one clock after it is sampled.
- R6: A high-byte fetch drives `entry_addr[15:8]`. For the reset vector, the high-byte fetch has `addr_lo` = 3'b101 and `vp_n` = 0.
- R7: While `vp_n` = 1 the block never drives the bus and never stalls, whatever the address.
- R8: With `NMI_EN` = 1, the NMI vector is served in the same way. Its low byte is at `addr_lo` = 3'b010 and its high byte at 3'b011.
- R9: The low byte is served first and the cycle ends when `phi2` falls. When a high-byte cycle then ends with a `phi2` fall, the block disarms. After that, vector fetches get `data_oe` = 0 and `rdy` = 1 until the next reset.
- R10: Vector fetches at other low addresses, such as 3'b110 (the interrupt vector), are not intercepted.
- R11: `load_done` is sticky. Once it has been seen, dropping it does not stop the vector from being served.
- R12: `mem_inhibit` is 1 exactly when `data_oe` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast synchronous clock |
| rst | input | 1 | Synchronous active-high reset; also re-arms the block |
| phi2 | input | 1 | CPU phase-2 clock level, sampled on `clk` |
| vp_n | input | 1 | Active-low vector-pull strobe from the CPU |
| addr_lo | input | 3 | Lowest CPU address lines |
| load_done | input | 1 | Loader reports that the bootstrap code is in RAM |
| entry_addr | input | 16 | Entry address returned as the vector contents |
| rdy | output | 1 | CPU ready line; 0 stalls the CPU |
| data_o | output | 8 | Byte offered to the CPU data bus |
| data_oe | output | 1 | Enable for the data-bus tri-state driver |
| mem_inhibit | output | 1 | Forces the RAM output enable inactive |

## Verification
The bench builds the block with its defaults: three address bits, NMI interception enabled, reset vector low byte at 3'b100. With these values both intercepted vectors, the interrupt vector that must be ignored, and the two byte orderings are all reachable. The phase-2 clock is stretched over several fast clocks. This exposes RDY holding through the high phase, and the one-clock lag between a sample and a driven byte. A second reset shows that the block re-arms, and that an NMI-only entry path works.

// File: rtl/vbi_pkg.sv
package vbi_pkg;
  typedef enum logic [1:0] {
    VB_NONE = 2'd0,
    VB_LO   = 2'd1,
    VB_HI   = 2'd2
  } vbyte_e;
endpackage

// File: rtl/vbi_match.sv
module vbi_match
  import vbi_pkg::*;
#(
  parameter int          AW        = 3,
  parameter logic [AW-1:0] RST_LO  = 3'b100,
  parameter logic [AW-1:0] NMI_LO  = 3'b010,
  parameter bit          NMI_EN    = 1'b1
) (
  input  logic          vp_n,
  input  logic [AW-1:0] addr_lo,
  output vbyte_e        vsel
);
  localparam logic [AW-1:0] RST_HI = RST_LO | AW'(1);
  localparam logic [AW-1:0] NMI_HI = NMI_LO | AW'(1);

  logic nmi_lo_hit, nmi_hi_hit;

  generate
    if (NMI_EN) begin : g_nmi
      assign nmi_lo_hit = (addr_lo == NMI_LO);
      assign nmi_hi_hit = (addr_lo == NMI_HI);
    end else begin : g_no_nmi
      assign nmi_lo_hit = 1'b0;
      assign nmi_hi_hit = 1'b0;
    end
  endgenerate

  always_comb begin
    vsel = VB_NONE;
    if (!vp_n) begin
      if (addr_lo == RST_LO || nmi_lo_hit)      vsel = VB_LO;
      else if (addr_lo == RST_HI || nmi_hi_hit) vsel = VB_HI;
    end
  end
endmodule

// File: rtl/vbi_rdy_gate.sv
module vbi_rdy_gate (
  input  logic clk,
  input  logic rst,
  input  logic phi2,
  input  logic stall_req,
  output logic rdy
);
  always_ff @(posedge clk) begin
    if (rst)        rdy <= 1'b1;
    else if (!phi2) rdy <= !stall_req;
  end
endmodule

// File: rtl/vbi_drive.sv
module vbi_drive
  import vbi_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          serve,
  input  vbyte_e        vsel,
  input  logic [2*DW-1:0] entry_addr,
  output logic [DW-1:0] data_o,
  output logic          data_oe,
  output logic          mem_inhibit
);
  logic drive_now;
  assign drive_now = serve && (vsel != VB_NONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      data_o      <= '0;
      data_oe     <= 1'b0;
      mem_inhibit <= 1'b0;
    end else begin
      data_o      <= (vsel == VB_HI) ? entry_addr[2*DW-1:DW] : entry_addr[DW-1:0];
      data_oe     <= drive_now;
      mem_inhibit <= drive_now;
    end
  end
endmodule

// File: rtl/vec_boot_intercept.sv
module vec_boot_intercept
  import vbi_pkg::*;
#(
  parameter int            AW     = 3,
  parameter int            DW     = 8,
  parameter logic [AW-1:0] RST_LO = 3'b100,
  parameter logic [AW-1:0] NMI_LO = 3'b010,
  parameter bit            NMI_EN = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          phi2,
  input  logic          vp_n,
  input  logic [AW-1:0] addr_lo,
  input  logic          load_done,
  input  logic [2*DW-1:0] entry_addr,
  output logic          rdy,
  output logic [DW-1:0] data_o,
  output logic          data_oe,
  output logic          mem_inhibit
);
  vbyte_e vsel;
  logic   armed, done_q, lo_served, phi2_q;
  logic   cycle_end, serve, stall_req;

  vbi_match #(.AW(AW), .RST_LO(RST_LO), .NMI_LO(NMI_LO), .NMI_EN(NMI_EN)) match_i (
    .vp_n(vp_n), .addr_lo(addr_lo), .vsel(vsel)
  );

  assign cycle_end = phi2_q && !phi2;
  assign serve     = armed && done_q;
  assign stall_req = armed && !done_q && (vsel != VB_NONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      armed     <= 1'b1;
      done_q    <= 1'b0;
      lo_served <= 1'b0;
      phi2_q    <= 1'b0;
    end else begin
      phi2_q <= phi2;
      if (load_done) done_q <= 1'b1;
      if (cycle_end && serve) begin
        if (vsel == VB_LO) lo_served <= 1'b1;
        if (vsel == VB_HI && lo_served) armed <= 1'b0;
      end
    end
  end

  vbi_rdy_gate rdy_i (
    .clk(clk), .rst(rst), .phi2(phi2), .stall_req(stall_req), .rdy(rdy)
  );

  vbi_drive #(.DW(DW)) drive_i (
    .clk(clk), .rst(rst), .serve(serve), .vsel(vsel), .entry_addr(entry_addr),
    .data_o(data_o), .data_oe(data_oe), .mem_inhibit(mem_inhibit)
  );
endmodule

// File: rtl/vec_boot_intercept_chk.sv
module vec_boot_intercept_chk #(
  parameter int AW = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          phi2,
  input logic          vp_n,
  input logic [AW-1:0] addr_lo,
  input logic          rdy,
  input logic          data_oe,
  input logic          mem_inhibit
);
  assert_inhibit_tracks_oe_R12: assert property (@(posedge clk) disable iff (rst)
    mem_inhibit == data_oe);

  assert_rdy_held_phi2_high_R3: assert property (@(posedge clk) disable iff (rst)
    phi2 |=> $stable(rdy));

  assert_no_drive_without_vp_R7: assert property (@(posedge clk) disable iff (rst)
    vp_n |=> !data_oe);

  assert_irq_vector_ignored_R10: assert property (@(posedge clk) disable iff (rst)
    (addr_lo == 3'b110) |=> !data_oe);

  assert_stall_needs_vp_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(rdy) |-> $past(!vp_n));
endmodule

bind vec_boot_intercept vec_boot_intercept_chk #(.AW(AW)) chk_i (
  .clk(clk), .rst(rst), .phi2(phi2), .vp_n(vp_n), .addr_lo(addr_lo),
  .rdy(rdy), .data_oe(data_oe), .mem_inhibit(mem_inhibit)
);

// File: tb/vec_boot_intercept_tb_top.sv
`timescale 1ns/1ps
module vec_boot_intercept_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic phi2 = 1'b0;
  logic vp_n = 1'b1;
  logic [2:0] addr_lo = 3'b000;
  logic load_done = 1'b0;
  logic [15:0] entry_addr = 16'hBEEF;
  logic rdy, data_oe, mem_inhibit;
  logic [7:0] data_o;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  vec_boot_intercept dut_i (
    .clk(clk), .rst(rst), .phi2(phi2), .vp_n(vp_n), .addr_lo(addr_lo),
    .load_done(load_done), .entry_addr(entry_addr), .rdy(rdy),
    .data_o(data_o), .data_oe(data_oe), .mem_inhibit(mem_inhibit)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; phi2 = 1'b0; vp_n = 1'b1; load_done = 1'b0;
    edges(2);
    rst = 1'b0;
  endtask

  task automatic t_reset_state();
    do_reset();
    edges(1);
    check("R1 rdy", {15'b0, rdy}, 16'h1);
    check("R1 oe", {15'b0, data_oe}, 16'h0);
    check("R1 inhibit", {15'b0, mem_inhibit}, 16'h0);
  endtask

  task automatic t_ignored();
    vp_n = 1'b1; addr_lo = 3'b100; phi2 = 1'b0;
    edges(2);
    check("R7 oe", {15'b0, data_oe}, 16'h0);
    check("R7 rdy", {15'b0, rdy}, 16'h1);
    vp_n = 1'b0; addr_lo = 3'b110;
    edges(2);
    check("R10 oe", {15'b0, data_oe}, 16'h0);
    check("R10 rdy", {15'b0, rdy}, 16'h1);
    vp_n = 1'b1;
  endtask

  task automatic t_stall_and_serve();
    entry_addr = 16'hBEEF;
    vp_n = 1'b0; addr_lo = 3'b100; phi2 = 1'b0;
    edges(1);
    check("R2 stall", {15'b0, rdy}, 16'h0);
    check("R2 no drive", {15'b0, data_oe}, 16'h0);
    phi2 = 1'b1; load_done = 1'b1;
    edges(3);
    check("R3 hold in phi2 high", {15'b0, rdy}, 16'h0);
    phi2 = 1'b0; load_done = 1'b0;
    edges(1);
    check("R4 release", {15'b0, rdy}, 16'h1);
    check("R5 low byte", {8'b0, data_o}, 16'h00EF);
    check("R5 oe", {15'b0, data_oe}, 16'h1);
    check("R12 inhibit", {15'b0, mem_inhibit}, 16'h1);
    phi2 = 1'b1; edges(1);
    phi2 = 1'b0; edges(1);
    addr_lo = 3'b101;
    edges(1);
    check("R11 sticky done", {15'b0, data_oe}, 16'h1);
    check("R6 high byte", {8'b0, data_o}, 16'h00BE);
    phi2 = 1'b1; edges(1);
    phi2 = 1'b0; edges(1);
    addr_lo = 3'b100;
    edges(2);
    check("R9 disarmed oe", {15'b0, data_oe}, 16'h0);
    check("R9 disarmed rdy", {15'b0, rdy}, 16'h1);
    check("R12 inhibit off", {15'b0, mem_inhibit}, 16'h0);
    vp_n = 1'b1;
  endtask

  task automatic t_nmi();
    do_reset();
    entry_addr = 16'h1234; load_done = 1'b1;
    edges(1);
    vp_n = 1'b0; addr_lo = 3'b010; phi2 = 1'b0;
    edges(1);
    check("R8 nmi no stall", {15'b0, rdy}, 16'h1);
    check("R8 nmi low", {7'b0, data_oe, data_o}, 16'h0134);
    addr_lo = 3'b011;
    edges(1);
    check("R8 nmi high", {7'b0, data_oe, data_o}, 16'h0112);
    vp_n = 1'b1;
    edges(1);
    check("R7 release bus", {15'b0, data_oe}, 16'h0);
  endtask

  initial begin
    fork
      begin
        t_reset_state();
        t_ignored();
        t_stall_and_serve();
        t_nmi();
      end
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule